// File: doc/BRIEF.md
# Serial Audio Data Transmitter

This block turns pairs of 24-bit two's-complement audio samples (one left, one right) into a single serial data line. The line is framed by a frame clock, whose level names the channel, and a bit clock, whose falling edges move the data. Both clocks enter the block as inputs, whether a local divider or an external device generates them. A system clock that runs much faster than the bit clock samples them, and `sd_o` changes one system-clock cycle after each detected falling edge of the bit clock. One select input chooses between two formats. In MSB-justified mode the most significant bit starts the slot. In I2S-compatible mode the frame-clock polarity is inverted and the MSB is delayed by one bit period.

Samples arrive through a valid/ready port backed by a single holding entry. `s_ready` is high only while the entry is empty and the block is powered up. A producer may hold `s_valid` high against a low `s_ready`, and nothing is taken until `s_ready` rises. The entry empties at the start of each left slot, when the whole pair moves to the serializer. If no pair is waiting at that point, the frame is sent as silence. A power-down input forces the data line low, drops `s_ready` and discards any pair that is waiting.

Top module: `audio_ser_tx`

## Requirements
- R1: While `pdn_n` is low, `sd_o` is 0 from the next system-clock cycle on and `s_ready` is 0. A pair held when power-down starts is discarded, and `s_ready` is 1 in the first cycle after `pdn_n` returns high.
- R2: With `fmt_i2s`=0 (MSB-justified), frame clock 1 marks the left slot and 0 marks the right slot. Sample bit 23 is driven in the first bit period of the slot, starting at the bit-clock falling edge where the frame clock changes.
- R3: With `fmt_i2s`=1 (I2S), frame clock 0 marks the left slot and 1 marks the right slot. Sample bit 23 is driven in the second bit period of the slot. The first period carries the next unsent bit of the previous channel, which is 0 when that slot held more than 24 periods.
- R4: Each sample goes out MSB first (bit 23 down to bit 0), unchanged. Any bit period after bit 0 within the same slot carries 0.
- R5: Slot lengths of 16, 24 and 32 bit periods (32, 48 and 64 bit clocks per frame) are accepted. With 16-period slots, only bits 23 down to 8 are sent.
- R6: `sd_o` changes only in the system-clock cycle that follows a detected bit-clock falling edge. It holds steady for the rest of the bit period.
- R7: The input port holds one pair. After a handshake (`s_valid` and `s_ready` both 1 at a clock edge), `s_ready` is 0 until the next left-slot start, and a pair offered meanwhile is not taken.
- R8: The left and right samples sent in one frame come from the same accepted pair, even when a new pair is accepted during that frame's left slot.
- R9: If no pair is held at a left-slot start, both slots of that frame send all-zero samples.
- R10: After reset or power-down, the first bit-clock falling edge only records the frame-clock level. `sd_o` stays 0 until a frame-clock change is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bit and frame clocks |
| rst_n | input | 1 | Asynchronous active-low reset |
| pdn_n | input | 1 | Active-low power-down and synchronous clear |
| fmt_i2s | input | 1 | Format select: 0 MSB-justified, 1 I2S-compatible |
| sclk_i | input | 1 | Bit clock, synchronous to `clk` |
| lrck_i | input | 1 | Frame clock, changes on bit-clock falling edges |
| s_valid | input | 1 | Sample pair offered |
| s_ready | output | 1 | Holding entry empty and powered up |
| s_left | input | 24 | Left sample, two's complement |
| s_right | input | 24 | Right sample, two's complement |
| sd_o | output | 1 | Serial data output |

## Verification
The assertions assume that the bit and frame clocks are already synchronous to `clk` and glitch-free. They also assume that each bit-clock level lasts several system-clock cycles and that the frame clock only moves on a bit-clock falling edge. The bench meets these assumptions by driving every input on the falling edge of `clk`. It holds each bit-clock half for four system-clock cycles and changes the frame clock in the same step as the bit-clock fall. It runs the handshake only while the bit clock is high, so back-pressure, power-down and format changes never land on a clock edge the design is decoding.

// File: rtl/audio_ser_pkg.sv
package audio_ser_pkg;
  localparam int SAMPLE_W = 24;

  typedef enum logic {
    FMT_MSBJ = 1'b0,
    FMT_I2S  = 1'b1
  } fmt_e;

  // Channel of the slot that begins at a frame-clock change.
  function automatic logic slot_is_left(logic lrck, fmt_e fmt);
    return (fmt == FMT_MSBJ) ? lrck : ~lrck;
  endfunction
endpackage

// File: rtl/audio_ser_edge.sv
module audio_ser_edge
  import audio_ser_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic pdn_n,
  input  logic fmt_i2s,
  input  logic sclk_i,
  input  logic lrck_i,
  output logic bit_fall,
  output logic slot_go,
  output logic left_go,
  output logic go_left
);
  logic sclk_q;
  logic lrck_last;
  logic primed;
  fmt_e fmt;

  assign fmt      = fmt_e'(fmt_i2s);
  assign bit_fall = pdn_n & sclk_q & ~sclk_i;
  assign go_left  = slot_is_left(lrck_i, fmt);
  assign slot_go  = bit_fall & primed & (lrck_i != lrck_last);
  assign left_go  = slot_go & go_left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q    <= 1'b0;
      lrck_last <= 1'b0;
      primed    <= 1'b0;
    end else begin
      sclk_q <= sclk_i;
      if (!pdn_n) begin
        primed <= 1'b0;
      end else if (bit_fall) begin
        lrck_last <= lrck_i;
        primed    <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/audio_ser_hold.sv
module audio_ser_hold #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         pdn_n,
  input  logic         s_valid,
  output logic         s_ready,
  input  logic [W-1:0] s_left,
  input  logic [W-1:0] s_right,
  input  logic         take,
  output logic [W-1:0] take_left,
  output logic [W-1:0] right_word
);
  logic         full;
  logic [W-1:0] hold_l;
  logic [W-1:0] hold_r;

  assign s_ready   = pdn_n & ~full;
  assign take_left = full ? hold_l : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full       <= 1'b0;
      hold_l     <= '0;
      hold_r     <= '0;
      right_word <= '0;
    end else if (!pdn_n) begin
      full       <= 1'b0;
      right_word <= '0;
    end else begin
      if (take) begin
        right_word <= full ? hold_r : '0;
        full       <= 1'b0;
      end
      if (s_valid && s_ready) begin
        full   <= 1'b1;
        hold_l <= s_left;
        hold_r <= s_right;
      end
    end
  end
endmodule

// File: rtl/audio_ser_shift.sv
module audio_ser_shift #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         pdn_n,
  input  logic         fmt_i2s,
  input  logic         bit_fall,
  input  logic         slot_go,
  input  logic [W-1:0] load_word,
  output logic         sd_o
);
  localparam int MSB = W - 1;

  logic [W-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh   <= '0;
      sd_o <= 1'b0;
    end else if (!pdn_n) begin
      sh   <= '0;
      sd_o <= 1'b0;
    end else if (slot_go) begin
      if (fmt_i2s) begin
        sd_o <= sh[MSB];
        sh   <= load_word;
      end else begin
        sd_o <= load_word[MSB];
        sh   <= {load_word[MSB-1:0], 1'b0};
      end
    end else if (bit_fall) begin
      sd_o <= sh[MSB];
      sh   <= {sh[MSB-1:0], 1'b0};
    end
  end
endmodule

// File: rtl/audio_ser_tx.sv
module audio_ser_tx
  import audio_ser_pkg::*;
#(
  parameter int W = SAMPLE_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         pdn_n,
  input  logic         fmt_i2s,
  input  logic         sclk_i,
  input  logic         lrck_i,
  input  logic         s_valid,
  output logic         s_ready,
  input  logic [W-1:0] s_left,
  input  logic [W-1:0] s_right,
  output logic         sd_o
);
  logic         bit_fall;
  logic         slot_go;
  logic         left_go;
  logic         go_left;
  logic [W-1:0] take_left;
  logic [W-1:0] right_word;
  logic [W-1:0] load_word;

  audio_ser_edge u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .pdn_n    (pdn_n),
    .fmt_i2s  (fmt_i2s),
    .sclk_i   (sclk_i),
    .lrck_i   (lrck_i),
    .bit_fall (bit_fall),
    .slot_go  (slot_go),
    .left_go  (left_go),
    .go_left  (go_left)
  );

  audio_ser_hold #(.W(W)) u_hold (
    .clk        (clk),
    .rst_n      (rst_n),
    .pdn_n      (pdn_n),
    .s_valid    (s_valid),
    .s_ready    (s_ready),
    .s_left     (s_left),
    .s_right    (s_right),
    .take       (left_go),
    .take_left  (take_left),
    .right_word (right_word)
  );

  assign load_word = go_left ? take_left : right_word;

  audio_ser_shift #(.W(W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .pdn_n     (pdn_n),
    .fmt_i2s   (fmt_i2s),
    .bit_fall  (bit_fall),
    .slot_go   (slot_go),
    .load_word (load_word),
    .sd_o      (sd_o)
  );
endmodule

// File: rtl/audio_ser_tx_chk.sv
module audio_ser_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic pdn_n,
  input logic sclk_i,
  input logic s_valid,
  input logic s_ready,
  input logic sd_o
);
  logic [1:0] cyc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cyc <= '0;
    else if (cyc != 2'd3) cyc <= cyc + 2'd1;
  end

  a_r1_pd_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !pdn_n |=> (sd_o == 1'b0));

  a_r1_pd_noready: assert property (@(posedge clk) disable iff (!rst_n)
    !pdn_n |-> !s_ready);

  a_r1_wake_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= 2'd1 && $rose(pdn_n)) |-> s_ready);

  a_r7_one_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready) |=> !s_ready);

  a_r6_change_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= 2'd2 && $past(pdn_n) && !($past(sclk_i, 2) && !$past(sclk_i)))
      |-> $stable(sd_o));
endmodule

bind audio_ser_tx audio_ser_tx_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .pdn_n   (pdn_n),
  .sclk_i  (sclk_i),
  .s_valid (s_valid),
  .s_ready (s_ready),
  .sd_o    (sd_o)
);

// File: tb/audio_ser_tx_bench.sv
module audio_ser_tx_bench;
  localparam int W = 24;
  localparam int H = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         pdn_n = 1'b1;
  logic         fmt_i2s = 1'b0;
  logic         sclk_b = 1'b1;
  logic         lrck_b = 1'b0;
  logic         s_valid = 1'b0;
  logic         s_ready;
  logic [W-1:0] s_left = '0;
  logic [W-1:0] s_right = '0;
  logic         sd_o;

  int n_chk = 0;
  int n_fail = 0;
  int exp_q[$];
  string tag_q[$];
  logic [W-1:0] prev_r = '0;

  always #5 clk = ~clk;

  audio_ser_tx u_audio_ser_tx (
    .clk(clk), .rst_n(rst_n), .pdn_n(pdn_n), .fmt_i2s(fmt_i2s),
    .sclk_i(sclk_b), .lrck_i(lrck_b), .s_valid(s_valid), .s_ready(s_ready),
    .s_left(s_left), .s_right(s_right), .sd_o(sd_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Monitor: pops one expected bit per bit-clock rise.
  always @(posedge sclk_b) begin : mon
    int e;
    string t;
    if (exp_q.size() != 0) begin
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      if (e != 2) chk(sd_o === e[0], t, int'(sd_o), e);
    end
  end

  function automatic int exp_bit(input logic [W-1:0] cur, input logic [W-1:0] prv,
                                 input int p, input int slot, input bit i2s);
    int k;
    logic [W-1:0] src;
    if (!i2s) begin k = p; src = cur; end
    else if (p == 0) begin k = slot - 1; src = prv; end
    else begin k = p - 1; src = cur; end
    return (k < W) ? int'(src[W-1-k]) : 0;
  endfunction

  // One bit period: fall (with frame level), then rise; pushes the expected bit.
  task automatic bitp(input logic lv, input int e, input string t);
    logic s1;
    @(negedge clk);
    sclk_b = 1'b0;
    lrck_b = lv;
    repeat (H) @(negedge clk);
    exp_q.push_back(e);
    tag_q.push_back(t);
    sclk_b = 1'b1;
    s1 = sd_o;
    repeat (H - 1) @(negedge clk);
    chk(sd_o === s1, "R6", int'(sd_o), int'(s1));
  endtask

  task automatic send(input logic [W-1:0] l, input logic [W-1:0] r);
    @(negedge clk);
    s_valid = 1'b1;
    s_left  = l;
    s_right = r;
    while (!s_ready) @(negedge clk);
    @(negedge clk);
    s_valid = 1'b0;
  endtask

  task automatic prime(input bit i2s, input bit check0);
    fmt_i2s = i2s;
    repeat (3) bitp(i2s ? 1'b1 : 1'b0, check0 ? 0 : 2, "R10");
  endtask

  task automatic run_frame(input logic [W-1:0] l, input logic [W-1:0] r, input int slot,
                           input bit i2s, input bit skip0, input bit send_it, input bit mute,
                           input string t, input bit nxt, input logic [W-1:0] nl,
                           input logic [W-1:0] nr);
    logic [W-1:0] wl, wr, cur, prv;
    logic lv;
    int e;
    if (send_it) send(l, r);
    wl = mute ? '0 : l;
    wr = mute ? '0 : r;
    for (int ch = 0; ch < 2; ch++) begin
      lv  = (ch == 0) ? ~i2s : i2s;
      cur = (ch == 0) ? wl : wr;
      prv = (ch == 0) ? prev_r : wl;
      for (int p = 0; p < slot; p++) begin
        e = exp_bit(cur, prv, p, slot, i2s);
        if (ch == 0 && p == 0 && skip0 && i2s) e = 2;
        bitp(lv, e, t);
        if (nxt && ch == 0 && p == 2) send(nl, nr);
      end
    end
    prev_r = wr;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(sd_o === 1'b0, "R1 reset sd_o", int'(sd_o), 0);
    chk(s_ready === 1'b1, "R1 reset ready", int'(s_ready), 1);

    // MSB-justified, 64 fs
    prime(1'b0, 1'b1);
    run_frame(24'h800001, 24'h7FFFFE, 32, 0, 1, 1, 0, "R2", 0, '0, '0);
    run_frame(24'hA5C3F0, 24'h123456, 32, 0, 0, 1, 0, "R4", 0, '0, '0);
    run_frame(24'hFFFFFF, 24'h000000, 32, 0, 0, 1, 0, "R2", 0, '0, '0);

    // I2S, 64 fs
    prime(1'b1, 1'b0);
    run_frame(24'h800001, 24'h7FFFFE, 32, 1, 1, 1, 0, "R3", 0, '0, '0);
    run_frame(24'h5A3C0F, 24'hC0FFEE, 32, 1, 0, 1, 0, "R3", 0, '0, '0);

    // 48 fs and 32 fs in both formats
    prime(1'b0, 1'b0);
    run_frame(24'hF0F00F, 24'h0F0FF1, 24, 0, 1, 1, 0, "R5", 0, '0, '0);
    run_frame(24'h800181, 24'hFFFF01, 16, 0, 0, 1, 0, "R5", 0, '0, '0);
    prime(1'b1, 1'b0);
    run_frame(24'h0000FF, 24'hFFFF01, 24, 1, 1, 1, 0, "R5", 0, '0, '0);
    run_frame(24'h3C0180, 24'h7F8101, 24, 1, 0, 1, 0, "R5", 0, '0, '0);
    run_frame(24'h12C3A5, 24'hE18100, 16, 1, 0, 1, 0, "R5", 0, '0, '0);
    run_frame(24'h000100, 24'h000100, 16, 1, 0, 1, 0, "R5", 0, '0, '0);

    // Back-pressure: one entry, second offer refused
    prime(1'b0, 1'b0);
    send(24'hBEEF01, 24'h10CAFE);
    chk(s_ready === 1'b0, "R7 ready low when full", int'(s_ready), 0);
    @(negedge clk);
    s_valid = 1'b1;
    s_left  = 24'h111111;
    s_right = 24'h222222;
    repeat (5) begin
      @(negedge clk);
      chk(s_ready === 1'b0, "R7 ready held low", int'(s_ready), 0);
    end
    s_valid = 1'b0;
    run_frame(24'hBEEF01, 24'h10CAFE, 32, 0, 1, 0, 0, "R7", 0, '0, '0);

    // Underrun: nothing held
    run_frame(24'h0, 24'h0, 32, 0, 0, 0, 1, "R9", 0, '0, '0);

    // Pair integrity: new pair accepted during left slot
    run_frame(24'h654321, 24'h9ABCDE, 32, 0, 0, 1, 0, "R8", 1, 24'h0F1E2D, 24'hC3B4A5);
    chk(s_ready === 1'b0, "R8 next pair held", int'(s_ready), 0);
    run_frame(24'h0F1E2D, 24'hC3B4A5, 32, 0, 0, 0, 0, "R8", 0, '0, '0);
    run_frame(24'h0, 24'h0, 32, 0, 0, 0, 1, "R9", 0, '0, '0);

    // Power-down with a pair held and sd_o high
    run_frame(24'h123456, 24'hFFFFFF, 16, 0, 0, 1, 0, "R5", 0, '0, '0);
    chk(sd_o === 1'b1, "R5 last bit of 16-period slot", int'(sd_o), 1);
    send(24'h777777, 24'h888888);
    @(negedge clk);
    pdn_n = 1'b0;
    repeat (2) @(negedge clk);
    chk(sd_o === 1'b0, "R1 sd_o low in power-down", int'(sd_o), 0);
    chk(s_ready === 1'b0, "R1 ready low in power-down", int'(s_ready), 0);
    pdn_n = 1'b1;
    @(negedge clk);
    chk(s_ready === 1'b1, "R1 held pair discarded", int'(s_ready), 1);
    prime(1'b0, 1'b1);
    prev_r = '0;
    run_frame(24'h0, 24'h0, 32, 0, 0, 0, 1, "R1", 0, '0, '0);

    repeat (4 * H) @(negedge clk);
    chk(exp_q.size() == 0, "R4 monitor drained", exp_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule